// File: doc/BRIEF.md
# Loopback Frame Generator and Checker

This block is a self-test traffic engine for a PCS-level Ethernet datapath. A host sets a frame count, a frame size and a payload pattern through a small register port, then writes a start command. The engine sends the frames on a 64-bit transmit media-independent bus with eight per-byte control flags, and it parses the receive bus, which is looped back from the transmit side. Each returning frame is compared against a locally regenerated copy of the expected payload.

Each received frame is counted as either a match or a mismatch. The run ends when every programmed frame has been accounted for, or when the receive side has been quiet for too long. A single result register then holds a fixed pass code or a fail code. The counters stay readable afterwards, so software can tell a dropped frame from a corrupted one.

Top module: `lbk_traffic_engine`

## Requirements
- R1: Register offsets are: 0x0 control (writing 0x01 starts a run; a read returns the busy flag in bit 0), 0x2 result, 0x6 frame count, 0x7 frame size in payload bytes, 0x8 match count, 0x9 mismatch count, 0xA frame type. Read data appears on `reg_rdata` one cycle after `reg_re` is asserted. Unmapped offsets read 0. After reset every register reads 0, except frame type, which reads 0x1.
- R2: The count, size and type registers read back the value last written. Count and size hold `CNT_W` bits, so 30 through 16384 are accepted.
- R3: A run sends exactly the programmed number of frames.
  - Framing is as follows. A start beat carries 0xFB with its control flag set in lane 0, and 0x55 data bytes in lanes 1 to 7.
  - Payload bytes follow, in lane order 0 to 7 on successive beats. Exactly the programmed number of payload bytes is sent.
  - A terminate byte 0xFD with its control flag set sits in the lane after the last payload byte. When the size is a multiple of 8, it sits in lane 0 of an extra beat. Lanes after the terminate carry the idle byte 0x07 with the control flag set.
  - At least `IFG` all-idle beats separate frames. Transmit is all-idle outside a run.
- R4: Frame type 0x1, and any value not listed in R5 or R6, selects the incrementing pattern: payload byte n equals n mod 256, with n counted from 0 in every frame.
- R5: Frame types 0x3 and 0x9 select the constant pattern: every payload byte equals the `CONST_BYTE` parameter.
- R6: Frame type 0x4 selects the pseudo-random pattern. A 32-bit state s is loaded with `SEED` at every frame start. Payload beat k uses the state after k steps. Within that beat, lanes 0 to 3 carry bytes 0 to 3 of s, and lanes 4 to 7 carry the inverted bytes 0 to 3 of s. One step is s = (s >> 1) XOR (s[0] ? `POLY` : 0).
- R7: A received frame counts as a match only if every payload byte equals the expected pattern, its length equals the programmed size, and it ends with the terminate byte. Otherwise it counts as one mismatch.
- R8: A run ends when matches plus mismatches equal the programmed count. The result then reads 0x53 if the mismatch count is 0, and 0x46 otherwise.
- R9: A start command clears both counters and the result register. The result reads 0x00 and control bit 0 reads 1 for as long as the run lasts.
- R10: If `TIMEOUT` consecutive cycles of a run see only all-control beats on the receive bus, the run ends with result 0x46 and transmission stops.
- R11: While a run is in progress, writes to the count, size and type registers and further start commands are ignored.
- R12: After a run ends, the match and mismatch counts keep their values until the next start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_rdata | output | DW | Read data, valid one cycle after `reg_re` |
| tx_data | output | 64 | Transmit bus data, eight byte lanes |
| tx_ctrl | output | 8 | Transmit per-lane control flags |
| rx_data | input | 64 | Receive bus data |
| rx_ctrl | input | 8 | Receive per-lane control flags |

## Verification
The bench builds the engine with `TIMEOUT` lowered to 64, `IFG` set to 2 and a non-default `CONST_BYTE` of 0x3C, keeping `CNT_W` at 16. The short timeout makes the quiet-receive abort reachable within a few dozen cycles when the bench cuts its loopback. The full 16-bit count width still allows a single 16384-byte frame to be sent and checked. The non-default constant byte separates the constant pattern from zero or reset-like data. The bench's own loopback can flip a payload byte, or cut a frame short, in a chosen frame. This lets mismatches of both content and length be placed at known positions.

// File: rtl/lbk_pkg.sv
`timescale 1ns/1ps
package lbk_pkg;

    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_PRE   = 8'h55;

    localparam logic [7:0] VERDICT_PASS = 8'h53;
    localparam logic [7:0] VERDICT_FAIL = 8'h46;

    localparam int OFS_CTRL   = 'h0;
    localparam int OFS_RESULT = 'h2;
    localparam int OFS_COUNT  = 'h6;
    localparam int OFS_SIZE   = 'h7;
    localparam int OFS_MATCH  = 'h8;
    localparam int OFS_MISS   = 'h9;
    localparam int OFS_TYPE   = 'hA;

    typedef enum logic [1:0] {
        PAT_INCR  = 2'd0,
        PAT_CONST = 2'd1,
        PAT_RAND  = 2'd2
    } pat_mode_e;

    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_START = 3'd1,
        TX_PAY   = 3'd2,
        TX_TERM  = 3'd3,
        TX_GAP   = 3'd4
    } tx_state_e;

    function automatic pat_mode_e type_to_mode(input logic [7:0] ftype);
        case (ftype)
            8'h03, 8'h09: return PAT_CONST;
            8'h04:        return PAT_RAND;
            default:      return PAT_INCR;
        endcase
    endfunction

    function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] poly);
        return {1'b0, s[31:1]} ^ (s[0] ? poly : 32'h0);
    endfunction

endpackage

// File: rtl/lbk_pattern.sv
`timescale 1ns/1ps
module lbk_pattern #(
    parameter logic [7:0]  CONST_BYTE = 8'hA5,
    parameter logic [31:0] SEED       = 32'hACE1_2468,
    parameter logic [31:0] POLY       = 32'hA300_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               advance,
    input  lbk_pkg::pat_mode_e mode,
    output logic [63:0]        word
);
    import lbk_pkg::*;

    typedef struct packed {
        logic [7:0]  base;
        logic [31:0] lfsr;
    } pat_s;

    pat_s q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.base = 8'h00;
            d.lfsr = SEED;
        end else if (advance) begin
            d.base = q.base + 8'd8;
            d.lfsr = lfsr_step(q.lfsr, POLY);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.base <= 8'h00;
            q.lfsr <= SEED;
        end else begin
            q <= d;
        end
    end

    for (genvar j = 0; j < 8; j++) begin : g_lane
        logic [7:0] rnd_byte;
        logic [7:0] lane_byte;
        if (j < 4) begin : g_lo
            assign rnd_byte = q.lfsr[8*j +: 8];
        end else begin : g_hi
            assign rnd_byte = ~q.lfsr[8*(j-4) +: 8];
        end
        assign lane_byte = (mode == PAT_CONST) ? CONST_BYTE :
                           (mode == PAT_RAND)  ? rnd_byte   :
                                                 q.base + 8'(j);
        assign word[8*j +: 8] = lane_byte;
    end

endmodule

// File: rtl/lbk_tx_seq.sv
`timescale 1ns/1ps
module lbk_tx_seq #(
    parameter int          CNT_W      = 16,
    parameter int          IFG        = 2,
    parameter logic [7:0]  CONST_BYTE = 8'hA5,
    parameter logic [31:0] SEED       = 32'hACE1_2468,
    parameter logic [31:0] POLY       = 32'hA300_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               run,
    input  logic [CNT_W-1:0]   frames,
    input  logic [CNT_W-1:0]   size,
    input  lbk_pkg::pat_mode_e mode,
    output logic [63:0]        txd,
    output logic [7:0]         txc
);
    import lbk_pkg::*;

    localparam int GAP_W = (IFG > 1) ? $clog2(IFG) : 1;

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] sent;
        logic [GAP_W-1:0] gap;
        logic [63:0]      txd;
        logic [7:0]       txc;
    } tx_s;

    tx_s         q, d;
    logic        pat_restart;
    logic        pat_adv;
    logic        frame_end;
    logic [63:0] pat_word;

    lbk_pattern #(.CONST_BYTE(CONST_BYTE), .SEED(SEED), .POLY(POLY)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pat_restart),
        .advance (pat_adv),
        .mode    (mode),
        .word    (pat_word)
    );

    always_comb begin
        d           = q;
        pat_restart = 1'b0;
        pat_adv     = 1'b0;
        frame_end   = 1'b0;
        d.txd       = {8{CH_IDLE}};
        d.txc       = 8'hFF;
        case (q.st)
            TX_IDLE: begin
                if (go && frames != '0) begin
                    d.st   = TX_START;
                    d.sent = '0;
                end
            end
            TX_START: begin
                d.txd       = {{7{CH_PRE}}, CH_START};
                d.txc       = 8'h01;
                pat_restart = 1'b1;
                d.rem       = size;
                d.st        = TX_PAY;
            end
            TX_PAY: begin
                pat_adv = 1'b1;
                for (int j = 0; j < 8; j++) begin
                    if (int'(q.rem) > j) begin
                        d.txd[8*j +: 8] = pat_word[8*j +: 8];
                        d.txc[j]        = 1'b0;
                    end else if (int'(q.rem) == j) begin
                        d.txd[8*j +: 8] = CH_TERM;
                    end
                end
                if (q.rem > CNT_W'(8)) begin
                    d.rem = q.rem - CNT_W'(8);
                end else if (q.rem == CNT_W'(8)) begin
                    d.st = TX_TERM;
                end else begin
                    frame_end = 1'b1;
                end
            end
            TX_TERM: begin
                d.txd[7:0] = CH_TERM;
                frame_end  = 1'b1;
            end
            TX_GAP: begin
                if (q.gap == '0) d.st  = TX_START;
                else             d.gap = q.gap - GAP_W'(1);
            end
            default: d.st = TX_IDLE;
        endcase
        if (frame_end) begin
            if (q.sent + CNT_W'(1) == frames) begin
                d.st   = TX_IDLE;
                d.sent = '0;
            end else begin
                d.sent = q.sent + CNT_W'(1);
                d.st   = TX_GAP;
                d.gap  = GAP_W'(IFG - 1);
            end
        end
        if (!run && !go) begin
            d.st   = TX_IDLE;
            d.sent = '0;
            d.txd  = {8{CH_IDLE}};
            d.txc  = 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= TX_IDLE;
            q.rem  <= '0;
            q.sent <= '0;
            q.gap  <= '0;
            q.txd  <= {8{CH_IDLE}};
            q.txc  <= 8'hFF;
        end else begin
            q <= d;
        end
    end

    assign txd = q.txd;
    assign txc = q.txc;

endmodule

// File: rtl/lbk_rx_check.sv
`timescale 1ns/1ps
module lbk_rx_check #(
    parameter int          CNT_W      = 16,
    parameter logic [7:0]  CONST_BYTE = 8'hA5,
    parameter logic [31:0] SEED       = 32'hACE1_2468,
    parameter logic [31:0] POLY       = 32'hA300_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [CNT_W-1:0]   size,
    input  lbk_pkg::pat_mode_e mode,
    input  logic [63:0]        rxd,
    input  logic [7:0]         rxc,
    output logic               done,
    output logic               ok
);
    import lbk_pkg::*;

    localparam int LEN_W = CNT_W + 1;

    typedef struct packed {
        logic             in_frame;
        logic [LEN_W-1:0] len;
        logic             bad;
        logic             done;
        logic             ok;
    } rx_s;

    rx_s         q, d;
    logic        pat_restart;
    logic        pat_adv;
    logic [63:0] exp_word;
    logic        found;
    logic [2:0]  pos;
    logic        mism;

    lbk_pattern #(.CONST_BYTE(CONST_BYTE), .SEED(SEED), .POLY(POLY)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pat_restart),
        .advance (pat_adv),
        .mode    (mode),
        .word    (exp_word)
    );

    always_comb begin
        found = 1'b0;
        pos   = 3'd0;
        for (int j = 7; j >= 0; j--) begin
            if (rxc[j]) begin
                found = 1'b1;
                pos   = 3'(j);
            end
        end
        mism = 1'b0;
        for (int j = 0; j < 8; j++) begin
            if ((!found || 3'(j) < pos) && rxd[8*j +: 8] != exp_word[8*j +: 8]) begin
                mism = 1'b1;
            end
        end
    end

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.ok        = 1'b0;
        pat_restart = 1'b0;
        pat_adv     = 1'b0;
        if (!en) begin
            d.in_frame = 1'b0;
        end else if (!q.in_frame) begin
            if (rxc[0] && rxd[7:0] == CH_START) begin
                d.in_frame  = 1'b1;
                d.len       = '0;
                d.bad       = 1'b0;
                pat_restart = 1'b1;
            end
        end else begin
            pat_adv = 1'b1;
            if (found) begin
                d.done     = 1'b1;
                d.ok       = !q.bad && !mism && (rxd[{pos, 3'b000} +: 8] == CH_TERM) &&
                             (q.len + LEN_W'(pos) == LEN_W'(size));
                d.in_frame = 1'b0;
            end else begin
                d.len = q.len + LEN_W'(8);
                d.bad = q.bad | mism;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign ok   = q.ok;

endmodule

// File: rtl/lbk_traffic_engine.sv
`timescale 1ns/1ps
module lbk_traffic_engine #(
    parameter int          DW         = 32,
    parameter int          AW         = 4,
    parameter int          CNT_W      = 16,
    parameter int          IFG        = 2,
    parameter int          TIMEOUT    = 1024,
    parameter logic [7:0]  CONST_BYTE = 8'hA5,
    parameter logic [31:0] SEED       = 32'hACE1_2468,
    parameter logic [31:0] POLY       = 32'hA300_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_we,
    input  logic          reg_re,
    output logic [DW-1:0] reg_rdata,
    output logic [63:0]   tx_data,
    output logic [7:0]    tx_ctrl,
    input  logic [63:0]   rx_data,
    input  logic [7:0]    rx_ctrl
);
    import lbk_pkg::*;

    localparam int TO_W = $clog2(TIMEOUT);

    typedef struct packed {
        logic             busy;
        logic [7:0]       result;
        logic [CNT_W-1:0] frames;
        logic [CNT_W-1:0] size;
        logic [7:0]       ftype;
        logic [CNT_W-1:0] match;
        logic [CNT_W-1:0] miss;
        logic [TO_W-1:0]  tocnt;
        logic [DW-1:0]    rdata;
    } eng_s;

    eng_s      q, d;
    logic      start_fire;
    logic      rx_done;
    logic      rx_ok;
    pat_mode_e mode;

    // plain views of the run state for the bound checker
    logic             busy_w;
    logic [7:0]       result_w;
    logic [CNT_W-1:0] frames_w;
    logic [CNT_W-1:0] size_w;
    logic [7:0]       ftype_w;
    logic [CNT_W-1:0] match_w;
    logic [CNT_W-1:0] miss_w;

    assign mode = type_to_mode(q.ftype);

    lbk_tx_seq #(
        .CNT_W(CNT_W), .IFG(IFG), .CONST_BYTE(CONST_BYTE), .SEED(SEED), .POLY(POLY)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (start_fire),
        .run    (q.busy),
        .frames (q.frames),
        .size   (q.size),
        .mode   (mode),
        .txd    (tx_data),
        .txc    (tx_ctrl)
    );

    lbk_rx_check #(
        .CNT_W(CNT_W), .CONST_BYTE(CONST_BYTE), .SEED(SEED), .POLY(POLY)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.busy),
        .size  (q.size),
        .mode  (mode),
        .rxd   (rx_data),
        .rxc   (rx_ctrl),
        .done  (rx_done),
        .ok    (rx_ok)
    );

    always_comb begin
        d          = q;
        start_fire = reg_we && (reg_addr == AW'(OFS_CTRL)) &&
                     (reg_wdata == DW'(1)) && !q.busy;

        if (reg_we && !q.busy) begin
            if (reg_addr == AW'(OFS_COUNT)) d.frames = reg_wdata[CNT_W-1:0];
            if (reg_addr == AW'(OFS_SIZE))  d.size   = reg_wdata[CNT_W-1:0];
            if (reg_addr == AW'(OFS_TYPE))  d.ftype  = reg_wdata[7:0];
        end

        if (start_fire) begin
            d.busy   = 1'b1;
            d.result = 8'h00;
            d.match  = '0;
            d.miss   = '0;
            d.tocnt  = '0;
        end else if (q.busy) begin
            if ({1'b0, q.match} + {1'b0, q.miss} == {1'b0, q.frames}) begin
                d.busy   = 1'b0;
                d.result = (q.miss == '0) ? VERDICT_PASS : VERDICT_FAIL;
            end else if (q.tocnt == TO_W'(TIMEOUT - 1)) begin
                d.busy   = 1'b0;
                d.result = VERDICT_FAIL;
            end else begin
                if (rx_done) begin
                    if (rx_ok) d.match = q.match + CNT_W'(1);
                    else       d.miss  = q.miss + CNT_W'(1);
                end
                d.tocnt = (rx_ctrl != 8'hFF) ? '0 : q.tocnt + TO_W'(1);
            end
        end

        d.rdata = '0;
        if (reg_re) begin
            case (int'(reg_addr))
                OFS_CTRL:   d.rdata = DW'(q.busy);
                OFS_RESULT: d.rdata = DW'(q.result);
                OFS_COUNT:  d.rdata = DW'(q.frames);
                OFS_SIZE:   d.rdata = DW'(q.size);
                OFS_MATCH:  d.rdata = DW'(q.match);
                OFS_MISS:   d.rdata = DW'(q.miss);
                OFS_TYPE:   d.rdata = DW'(q.ftype);
                default:    d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.ftype <= 8'h01;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata = q.rdata;
    assign busy_w    = q.busy;
    assign result_w  = q.result;
    assign frames_w  = q.frames;
    assign size_w    = q.size;
    assign ftype_w   = q.ftype;
    assign match_w   = q.match;
    assign miss_w    = q.miss;

endmodule

// File: rtl/lbk_traffic_engine_sva.sv
`timescale 1ns/1ps
module lbk_traffic_engine_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [7:0]       result,
    input logic [CNT_W-1:0] frames,
    input logic [CNT_W-1:0] size,
    input logic [7:0]       ftype,
    input logic [CNT_W-1:0] match,
    input logic [CNT_W-1:0] miss,
    input logic [63:0]      tx_data,
    input logic [7:0]       tx_ctrl
);
    assert_result_clear_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> result == 8'h00);

    assert_no_overcount_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, match} + {1'b0, miss} <= {1'b0, frames}));

    assert_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ((result == 8'h53) == (miss == '0 && match == frames)) &&
                        (result == 8'h53 || result == 8'h46));

    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(frames) && $stable(size) && $stable(ftype));

    assert_counts_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !$past(busy) |-> $stable(match) && $stable(miss));

    assert_start_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctrl[0] && tx_data[7:0] == 8'hFB) |->
            (tx_ctrl[7:1] == 7'h00) && (tx_data[63:8] == {7{8'h55}}));

    assert_quiet_outside_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !$past(busy) |-> tx_ctrl == 8'hFF);

endmodule

bind lbk_traffic_engine lbk_traffic_engine_sva #(.CNT_W(CNT_W)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_w),
    .result  (result_w),
    .frames  (frames_w),
    .size    (size_w),
    .ftype   (ftype_w),
    .match   (match_w),
    .miss    (miss_w),
    .tx_data (tx_data),
    .tx_ctrl (tx_ctrl)
);

// File: tb/tb_lbk_traffic_engine.sv
`timescale 1ns/1ps
module tb_lbk_traffic_engine;

    localparam int          DW      = 32;
    localparam int          AW      = 4;
    localparam int          CNT_W   = 16;
    localparam int          IFG     = 2;
    localparam int          TIMEOUT = 64;
    localparam logic [7:0]  CBYTE   = 8'h3C;
    localparam logic [31:0] SEED    = 32'hACE1_2468;
    localparam logic [31:0] POLY    = 32'hA300_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic          reg_re = 1'b0;
    logic [DW-1:0] reg_rdata;
    logic [63:0]   tx_data;
    logic [7:0]    tx_ctrl;
    logic [63:0]   rx_data = {8{8'h07}};
    logic [7:0]    rx_ctrl = 8'hFF;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    lbk_traffic_engine #(
        .DW(DW), .AW(AW), .CNT_W(CNT_W), .IFG(IFG), .TIMEOUT(TIMEOUT),
        .CONST_BYTE(CBYTE), .SEED(SEED), .POLY(POLY)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata),
        .tx_data(tx_data), .tx_ctrl(tx_ctrl),
        .rx_data(rx_data), .rx_ctrl(rx_ctrl)
    );

    // ---------------- loopback with fault injection ----------------
    int          lb_mode = 0;    // 0 pass, 1 cut, 2 flip a byte, 3 shorten
    int          lb_target = -1;
    int          lb_cnt = 0;
    int          lb_beat = 0;
    bit          lb_in = 0;
    logic [63:0] s1_d = {8{8'h07}};
    logic [7:0]  s1_c = 8'hFF;

    always @(posedge clk) begin
        logic [63:0] d;
        logic [7:0]  c;
        d = tx_data;
        c = tx_ctrl;
        if (tx_ctrl[0] && tx_data[7:0] == 8'hFB) begin
            lb_cnt  <= lb_cnt + 1;
            lb_beat <= 0;
            lb_in   <= 1;
        end else if (lb_in) begin
            lb_beat <= lb_beat + 1;
            if (tx_ctrl != 8'h00) lb_in <= 0;
            if (lb_mode == 2 && lb_cnt - 1 == lb_target && lb_beat == 0)
                d[15:8] = d[15:8] ^ 8'h01;
            if (lb_mode == 3 && lb_cnt - 1 == lb_target) begin
                if (lb_beat == 0) begin
                    d = {{4{8'h07}}, 8'hFD, tx_data[23:0]};
                    c = 8'hF8;
                end else begin
                    d = {8{8'h07}};
                    c = 8'hFF;
                end
            end
        end
        if (lb_mode == 1) begin
            d = {8{8'h07}};
            c = 8'hFF;
        end
        s1_d    <= d;
        s1_c    <= c;
        rx_data <= s1_d;
        rx_ctrl <= s1_c;
    end

    // ---------------- independent transmit monitor ----------------
    logic [7:0]  cur_type = 8'h01;
    int          cur_size = 0;
    int          mon_frames = 0;
    int          mon_bad = 0;
    bit          mon_in = 0;
    bit          mon_after = 0;
    int          mon_pos = 0;
    int          mon_gap = 0;
    logic [31:0] mon_s = SEED;

    function automatic logic [31:0] m_step(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? POLY : 32'h0);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] t, input int pos,
                                            input logic [31:0] s, input int lane);
        case (t)
            8'h03, 8'h09: return CBYTE;
            8'h04:        return (lane < 4) ? s[8*lane +: 8] : ~s[8*(lane-4) +: 8];
            default:      return 8'(pos);
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_ctrl[0] && tx_data[7:0] == 8'hFB) begin
                if (tx_ctrl[7:1] != 7'h00 || tx_data[63:8] != {7{8'h55}}) mon_bad++;
                if (mon_after && mon_gap < IFG) mon_bad++;
                mon_in  = 1;
                mon_pos = 0;
                mon_s   = SEED;
            end else if (mon_in) begin
                bit ended;
                ended = 0;
                for (int j = 0; j < 8; j++) begin
                    if (!ended) begin
                        if (tx_ctrl[j]) begin
                            ended = 1;
                            if (tx_data[8*j +: 8] != 8'hFD) mon_bad++;
                            if (mon_pos != cur_size) mon_bad++;
                            mon_frames++;
                            mon_in    = 0;
                            mon_after = 1;
                            mon_gap   = 0;
                        end else begin
                            if (tx_data[8*j +: 8] != exp_byte(cur_type, mon_pos, mon_s, j)) mon_bad++;
                            mon_pos++;
                        end
                    end else if (!tx_ctrl[j] || tx_data[8*j +: 8] != 8'h07) begin
                        mon_bad++;
                    end
                end
                if (!ended) mon_s = m_step(mon_s);
            end else begin
                mon_gap++;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input int a, input int v);
        @(negedge clk);
        reg_addr  = AW'(a);
        reg_wdata = DW'(v);
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_read(input int a, output int v);
        @(negedge clk);
        reg_addr = AW'(a);
        reg_re   = 1'b1;
        @(negedge clk);
        v      = int'(reg_rdata);
        reg_re = 1'b0;
    endtask

    task automatic launch(input int nf, input int sz, input int t, input int mode, input int tgt);
        reg_write('h6, nf);
        reg_write('hA, t);
        reg_write('h7, sz);
        lb_mode    = mode;
        lb_target  = lb_cnt + tgt;
        cur_type   = 8'(t);
        cur_size   = sz;
        mon_frames = 0;
        mon_bad    = 0;
        mon_after  = 0;
        reg_write('h0, 1);
    endtask

    task automatic wait_idle();
        int v;
        int n;
        n = 0;
        do begin
            reg_read('h0, v);
            n++;
        end while ((v & 1) != 0 && n < 20000);
    endtask

    task automatic run_case(input string tag, input int nf, input int sz, input int t,
                            input int mode, input int tgt);
        int v;
        int em;
        int ex;
        launch(nf, sz, t, mode, tgt);
        reg_read('h2, v);
        chk({tag, " R9 result zero during run"}, v, 0);
        reg_read('h0, v);
        chk({tag, " R9 busy flag set"}, v & 1, 1);
        wait_idle();
        ex = (mode == 2 || mode == 3) ? 1 : 0;
        em = (mode == 1) ? 0 : nf - ex;
        reg_read('h8, v);
        chk({tag, " R7 match count"}, v, em);
        reg_read('h9, v);
        chk({tag, " R7 mismatch count"}, v, (mode == 1) ? 0 : ex);
        reg_read('h2, v);
        chk({tag, " R8/R10 result code"}, v, (ex == 0 && mode != 1) ? 'h53 : 'h46);
        if (mode != 1) begin
            chk({tag, " R3 frames sent"}, mon_frames, nf);
            chk({tag, " R3/R4/R5/R6 transmit content"}, mon_bad, 0);
        end
        lb_mode = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 150000);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired (all requirements)");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int v;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values and map
        reg_read('h0, v); chk("R1 ctrl reset", v, 0);
        reg_read('h2, v); chk("R1 result reset", v, 0);
        reg_read('h6, v); chk("R1 count reset", v, 0);
        reg_read('h7, v); chk("R1 size reset", v, 0);
        reg_read('h8, v); chk("R1 match reset", v, 0);
        reg_read('h9, v); chk("R1 mismatch reset", v, 0);
        reg_read('hA, v); chk("R1 type reset", v, 1);
        reg_read('h3, v); chk("R1 unmapped reads zero", v, 0);

        // R2 readback at limits
        reg_write('h6, 16384); reg_read('h6, v); chk("R2 count readback 16384", v, 16384);
        reg_write('h7, 16384); reg_read('h7, v); chk("R2 size readback 16384", v, 16384);
        reg_write('hA, 4);     reg_read('hA, v); chk("R2 type readback", v, 4);
        reg_write('h6, 30);    reg_read('h6, v); chk("R2 count readback 30", v, 30);

        // directed patterns and framing corners
        run_case("incr",        3, 30, 'h1, 0, 0);   // R4
        run_case("const8",      2, 64, 'h3, 0, 0);   // R5, size multiple of 8
        run_case("constcrc",    2, 33, 'h9, 0, 0);   // R5
        run_case("random",      3, 37, 'h4, 0, 0);   // R6
        run_case("othertype",   2, 300, 'h2, 0, 0);  // R4 fallback, wraps past 255
        run_case("bigframe",    1, 16384, 'h1, 0, 0);// R2/R3 largest size
        run_case("manyframes", 30, 30, 'h4, 0, 0);   // R3 count 30
        run_case("flip",        4, 40, 'h1, 2, 2);   // R7 content error
        run_case("short",       3, 45, 'h4, 3, 0);   // R7 length error
        run_case("cut",         5, 50, 'h1, 1, 0);   // R10 timeout

        // R11 writes and restart during a run are ignored
        launch(6, 100, 'h3, 0, 0);
        reg_write('h6, 99);
        reg_write('h7, 31);
        reg_write('h0, 1);
        reg_read('h6, v); chk("R11 count write ignored while busy", v, 6);
        reg_read('h7, v); chk("R11 size write ignored while busy", v, 100);
        wait_idle();
        reg_read('h8, v); chk("R11 restart ignored, match count", v, 6);
        reg_read('h2, v); chk("R11 run verdict", v, 'h53);
        chk("R11 frames sent", mon_frames, 6);

        // R12 counters persist after the run
        repeat (20) @(negedge clk);
        reg_write('h6, 7);
        reg_read('h8, v); chk("R12 match held", v, 6);
        reg_read('h9, v); chk("R12 mismatch held", v, 0);
        reg_read('h2, v); chk("R12 result held", v, 'h53);

        // constrained random runs
        for (int it = 0; it < 12; it++) begin
            int nf;
            int sz;
            int t;
            int md;
            int tg;
            int pick;
            nf   = 1 + int'($urandom_range(5));
            sz   = 30 + int'($urandom_range(170));
            pick = int'($urandom_range(4));
            t    = (pick == 0) ? 'h1 : (pick == 1) ? 'h3 : (pick == 2) ? 'h4 : (pick == 3) ? 'h9 : 'h2;
            md   = ($urandom_range(2) == 0) ? 2 : 0;
            tg   = int'($urandom_range(nf - 1));
            run_case($sformatf("rand%0d", it), nf, sz, t, md, tg);
        end

        done_flag = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule